// File: doc/BRIEF.md
# Serial EEPROM Status and Write-Guard Unit

This unit keeps the protection state of a serial EEPROM: the write-enable latch, a protect-pin enable flag and a two-bit block-protect field. It assembles the status byte that a status read shifts out. It also tells the rest of the device, cycle by cycle, whether a write to a given array address may go ahead and whether a status-register write would be accepted.

The serial front end does not live here. It reports each frame when chip-select rises, giving the decoded command kind, the number of bits clocked in during the frame and, for a status write, the data byte. The write sequencer reports when an internal write cycle has finished. The in-progress flag and the active-low protect pin arrive as levels. The protection flags would be nonvolatile in a real device; here they are ordinary flops that clear on reset.

Top module: `eeprom_status_guard`

## Requirements
- R1: `status_byte` carries, from bit 7 down: protect-pin enable, three zero bits, block-protect high bit, block-protect low bit, write-enable latch, and the `wip` input. Bit 0 follows `wip` in the same cycle, so the byte can be read at any time, including during a write cycle.
- R2: After reset, the latch, the protect-pin enable and both block-protect bits are 0.
- R3: The latch is set only by a frame end (`op_end`=1) with `op_kind`=1 (enable) and `op_bits`=8. It is set from the cycle after that edge. An enable frame with any other bit count, or any other kind with 8 bits, leaves the latch unchanged.
- R4: A frame end with `op_kind`=2 (disable) and `op_bits`=8 clears the latch. This holds whatever the protect flags, the protect pin and `wip` are.
- R5: An accepted status write is a frame end with `op_kind`=3 and `op_bits`=16 while `status_wr_ok`=1. It loads the protect-pin enable from data bit 7 and the block-protect field from data bits 3:2, and it clears the latch. Data bits 6:4 and 1:0 are ignored. A status-write frame with any other bit count changes nothing.
- R6: `status_wr_ok` is 1 exactly when the latch is set, `wip`=0, and not (protect-pin enable=1 and `wp_n`=0). A refused status write changes no flag, including the latch. When the protect-pin enable is 0, `wp_n` has no effect.
- R7: A pulse on `write_done` clears the latch.
- R8: `array_wr_ok` is 1 only when the latch is set, `wip`=0 and `addr` lies outside the protected region.
- R9: Block-protect value 00 protects nothing. Value 01 protects the top quarter (the two address MSBs are 11). Value 10 protects the upper half (the address MSB is 1). Value 11 protects every address.
- R10: When an enable frame end and `write_done` fall in the same cycle, the latch ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_end | input | 1 | Pulse: chip-select rose, ending a frame |
| op_kind | input | 3 | Decoded command of the frame: 0 none, 1 enable, 2 disable, 3 status write, 4 array write, 5 read |
| op_bits | input | CNT_W (8) | Bits clocked in during the frame, saturating |
| wrsr_data | input | 8 | Data byte of a status-write frame |
| write_done | input | 1 | Pulse: internal write cycle finished |
| wip | input | 1 | Write cycle in progress |
| wp_n | input | 1 | Write-protect pin, active low |
| addr | input | ADDR_W (15) | Array address under test |
| status_byte | output | 8 | Status byte for reads |
| wel | output | 1 | Write-enable latch state |
| array_wr_ok | output | 1 | Array write at `addr` allowed |
| status_wr_ok | output | 1 | Status write would be accepted |

## Verification
The latch is driven through enable frames with the right and the wrong bit count, with mismatched command kinds, and with an enable that coincides with a write-completion pulse. These cases separate a rule that checks the frame length from one that only looks at the command. Status writes are tried with the latch set and clear, with `wip` high, with the protect pin low under both values of the protect-pin enable, and with a wrong frame length. Each block-protect setting is probed at the addresses just below and just above its boundary, which catches an off-by-one region or swapped field bits.

// File: rtl/esg_pkg.sv
package esg_pkg;

  typedef enum logic [2:0] {
    OPK_NONE  = 3'd0,
    OPK_EN    = 3'd1,
    OPK_DIS   = 3'd2,
    OPK_STSWR = 3'd3,
    OPK_ARRWR = 3'd4,
    OPK_READ  = 3'd5
  } op_kind_e;

  typedef struct packed {
    logic       pin_en;
    logic [1:0] blk;
  } prot_flags_t;

  localparam int unsigned STS_PINEN_BIT = 7;
  localparam int unsigned STS_BLKHI_BIT = 3;
  localparam int unsigned STS_BLKLO_BIT = 2;

endpackage

// File: rtl/esg_rst_sync.sv
module esg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/esg_wel_latch.sv
module esg_wel_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic wel_q
);
  logic wel_d;
  logic wel_en;

  // Set wins over clear when both arrive in one cycle.
  always_comb begin
    wel_en = set_evt | clr_evt;
    wel_d  = set_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wel_q <= 1'b0;
    else if (wel_en) wel_q <= wel_d;
  end
endmodule

// File: rtl/esg_prot_regs.sv
module esg_prot_regs
  import esg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [7:0]  data,
  output prot_flags_t flags_q
);
  prot_flags_t flags_d;
  logic        unused_data_bits;

  assign unused_data_bits = ^{data[6:4], data[1:0]};

  always_comb begin
    flags_d.pin_en = data[STS_PINEN_BIT];
    flags_d.blk    = {data[STS_BLKHI_BIT], data[STS_BLKLO_BIT]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flags_q <= '0;
    else if (load) flags_q <= flags_d;
  end
endmodule

// File: rtl/esg_region_chk.sv
module esg_region_chk #(
  parameter int unsigned ADDR_W = 15
) (
  input  logic [1:0]        blk,
  input  logic [ADDR_W-1:0] addr,
  output logic              locked
);
  localparam int unsigned MSB = ADDR_W - 1;

  logic top_half;
  logic top_quarter;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign top_quarter = addr[MSB] & addr[MSB-1];
    end else begin : g_narrow
      assign top_quarter = addr[MSB];
    end
  endgenerate

  assign top_half = addr[MSB];

  always_comb begin
    unique case (blk)
      2'b00:   locked = 1'b0;
      2'b01:   locked = top_quarter;
      2'b10:   locked = top_half;
      default: locked = 1'b1;
    endcase
  end
endmodule

// File: rtl/eeprom_status_guard.sv
module eeprom_status_guard
  import esg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned INSTR_BITS = 8,
  parameter int unsigned STSWR_BITS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_end,
  input  logic [2:0]        op_kind,
  input  logic [CNT_W-1:0]  op_bits,
  input  logic [7:0]        wrsr_data,
  input  logic              write_done,
  input  logic              wip,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        status_byte,
  output logic              wel,
  output logic              array_wr_ok,
  output logic              status_wr_ok
);
  localparam logic [CNT_W-1:0] N_INSTR = CNT_W'(INSTR_BITS);
  localparam logic [CNT_W-1:0] N_STSWR = CNT_W'(STSWR_BITS);

  logic        rst_n_s;
  op_kind_e    kind;
  logic        is_en, is_dis, is_stswr;
  logic        set_evt, clr_evt, sts_load;
  logic        pin_block, addr_locked;
  prot_flags_t flags;

  esg_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_s)
  );

  always_comb begin
    kind     = op_kind_e'(op_kind);
    is_en    = op_end && (kind == OPK_EN)    && (op_bits == N_INSTR);
    is_dis   = op_end && (kind == OPK_DIS)   && (op_bits == N_INSTR);
    is_stswr = op_end && (kind == OPK_STSWR) && (op_bits == N_STSWR);
    pin_block    = flags.pin_en & ~wp_n;
    status_wr_ok = wel & ~wip & ~pin_block;
    sts_load     = is_stswr & status_wr_ok;
    set_evt      = is_en;
    clr_evt      = is_dis | sts_load | write_done;
    array_wr_ok  = wel & ~wip & ~addr_locked;
  end

  esg_wel_latch u_wel (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .set_evt (set_evt),
    .clr_evt (clr_evt),
    .wel_q   (wel)
  );

  esg_prot_regs u_prot (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load    (sts_load),
    .data    (wrsr_data),
    .flags_q (flags)
  );

  esg_region_chk #(.ADDR_W(ADDR_W)) u_region (
    .blk    (flags.blk),
    .addr   (addr),
    .locked (addr_locked)
  );

  assign status_byte = {flags.pin_en, 3'b000, flags.blk, wel, wip};
endmodule

// File: rtl/esg_checker.sv
module esg_checker #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_end,
  input logic [2:0]        op_kind,
  input logic [CNT_W-1:0]  op_bits,
  input logic [7:0]        wrsr_data,
  input logic              write_done,
  input logic              wip,
  input logic              wp_n,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        status_byte,
  input logic              wel,
  input logic              array_wr_ok,
  input logic              status_wr_ok
);
  logic stswr_frame;
  assign stswr_frame = op_end && (op_kind == 3'd3) && (op_bits == CNT_W'(16));

  a_r3_set_only_by_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(op_end && (op_kind == 3'd1) && (op_bits == CNT_W'(8))));

  a_r5_status_load: assert property (@(posedge clk) disable iff (!rst_n)
    (stswr_frame && status_wr_ok) |=>
      (status_byte[7] == $past(wrsr_data[7])) &&
      (status_byte[3:2] == $past(wrsr_data[3:2])) && !wel);

  a_r6_refused_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (stswr_frame && !status_wr_ok && !write_done) |=> $stable(status_byte[7:1]));

  a_r6_pin_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[7] && !wp_n) |-> !status_wr_ok);

  a_r7_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (write_done && !(op_end && op_kind == 3'd1)) |=> !wel);

  a_r8_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    array_wr_ok |-> (wel && !wip));

  a_r9_all_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[3:2] == 2'b11) |-> !array_wr_ok);

  a_r9_top_half: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[3:2] == 2'b10 && addr[ADDR_W-1]) |-> !array_wr_ok);
endmodule

bind eeprom_status_guard esg_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_end       (op_end),
  .op_kind      (op_kind),
  .op_bits      (op_bits),
  .wrsr_data    (wrsr_data),
  .write_done   (write_done),
  .wip          (wip),
  .wp_n         (wp_n),
  .addr         (addr),
  .status_byte  (status_byte),
  .wel          (wel),
  .array_wr_ok  (array_wr_ok),
  .status_wr_ok (status_wr_ok)
);

// File: tb/eeprom_status_guard_test.sv
`timescale 1ns/1ps
module eeprom_status_guard_test;
  localparam int unsigned ADDR_W = 15;
  localparam int unsigned CNT_W  = 8;

  typedef struct {
    string      req;
    logic [7:0] st;
    logic       aok;
    logic       sok;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              op_end;
  logic [2:0]        op_kind;
  logic [CNT_W-1:0]  op_bits;
  logic [7:0]        wrsr_data;
  logic              write_done;
  logic              wip;
  logic              wp_n;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        status_byte;
  logic              wel;
  logic              array_wr_ok;
  logic              status_wr_ok;

  int checks   = 0;
  int failures = 0;
  exp_t sb_q[$];
  bit done = 1'b0;

  // bench model of the flags
  logic m_wel, m_pin;
  logic [1:0] m_blk;

  always #2.5 clk = ~clk;

  eeprom_status_guard #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .op_end(op_end), .op_kind(op_kind),
    .op_bits(op_bits), .wrsr_data(wrsr_data), .write_done(write_done),
    .wip(wip), .wp_n(wp_n), .addr(addr), .status_byte(status_byte),
    .wel(wel), .array_wr_ok(array_wr_ok), .status_wr_ok(status_wr_ok)
  );

  function automatic logic m_locked();
    case (m_blk)
      2'b00:   return 1'b0;
      2'b01:   return addr[ADDR_W-1] & addr[ADDR_W-2];
      2'b10:   return addr[ADDR_W-1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic m_sok();
    return m_wel & ~wip & ~(m_pin & ~wp_n);
  endfunction

  task automatic push(input string req);
    exp_t e;
    e.req = req;
    e.st  = {m_pin, 3'b000, m_blk, m_wel, wip};
    e.aok = m_wel & ~wip & ~m_locked();
    e.sok = m_sok();
    sb_q.push_back(e);
  endtask

  // frame end and/or write completion in one cycle
  task automatic frame(input string req, input logic fe, input logic [2:0] k,
                       input int bits, input logic [7:0] d, input logic wd);
    logic set, clr;
    @(negedge clk);
    op_end = fe; op_kind = k; op_bits = CNT_W'(bits); wrsr_data = d; write_done = wd;
    set = fe && k == 3'd1 && bits == 8;
    clr = wd || (fe && k == 3'd2 && bits == 8);
    if (fe && k == 3'd3 && bits == 16 && m_sok()) begin
      m_pin = d[7]; m_blk = d[3:2]; clr = 1'b1;
    end
    if (set) m_wel = 1'b1; else if (clr) m_wel = 1'b0;
    @(posedge clk);
    #1;
    op_end = 1'b0; op_kind = 3'd0; op_bits = '0; write_done = 1'b0;
    push(req);
  endtask

  task automatic env(input string req, input logic w, input logic p, input logic [ADDR_W-1:0] a);
    @(posedge clk);
    #1;
    wip = w; wp_n = p; addr = a;
    push(req);
  endtask

  // monitor: compares one expected item per falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() != 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (status_byte !== e.st || array_wr_ok !== e.aok || status_wr_ok !== e.sok
            || wel !== e.st[1]) begin
          failures++;
          $display("FAIL %s: status=%02h aok=%0b sok=%0b wel=%0b expected status=%02h aok=%0b sok=%0b",
                   e.req, status_byte, array_wr_ok, status_wr_ok, wel, e.st, e.aok, e.sok);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_end = 1'b0; op_kind = 3'd0; op_bits = '0; wrsr_data = '0;
    write_done = 1'b0; wip = 1'b0; wp_n = 1'b1; addr = '0;
    m_wel = 1'b0; m_pin = 1'b0; m_blk = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    env("R2 reset state", 1'b0, 1'b1, '0);
    env("R1 wip bit", 1'b1, 1'b1, '0);
    env("R1 wip cleared", 1'b0, 1'b1, '0);
    frame("R3 enable with 9 bits", 1'b1, 3'd1, 9, 8'h00, 1'b0);
    frame("R3 array-write kind, 8 bits", 1'b1, 3'd4, 8, 8'h00, 1'b0);
    frame("R3 enable 8 bits", 1'b1, 3'd1, 8, 8'h00, 1'b0);
    env("R1 R8 read during write cycle", 1'b1, 1'b1, '0);
    env("R6 wip cleared", 1'b0, 1'b1, '0);
    frame("R5 status write ignores bits 6:4,1:0", 1'b1, 3'd3, 16, 8'hFF, 1'b0);
    frame("R3 enable again", 1'b1, 3'd1, 8, 8'h00, 1'b0);
    env("R9 all locked", 1'b0, 1'b1, '0);
    env("R6 pin low with enable set", 1'b0, 1'b0, '0);
    frame("R6 refused status write", 1'b1, 3'd3, 16, 8'h00, 1'b0);
    env("R4 wip high before disable", 1'b1, 1'b0, '0);
    frame("R4 disable under protection and wip", 1'b1, 3'd2, 8, 8'h00, 1'b0);
    env("R4 wip low", 1'b0, 1'b1, '0);
    frame("R6 status write with latch clear", 1'b1, 3'd3, 16, 8'h00, 1'b0);
    frame("R3 enable", 1'b1, 3'd1, 8, 8'h00, 1'b0);
    frame("R5 set quarter protect", 1'b1, 3'd3, 16, 8'h04, 1'b0);
    frame("R3 enable", 1'b1, 3'd1, 8, 8'h00, 1'b0);
    env("R9 quarter boundary above", 1'b0, 1'b1, 15'h6000);
    env("R9 quarter boundary below", 1'b0, 1'b1, 15'h5FFF);
    frame("R5 wrong length status write", 1'b1, 3'd3, 15, 8'h08, 1'b0);
    frame("R5 set half protect", 1'b1, 3'd3, 16, 8'h08, 1'b0);
    frame("R3 enable", 1'b1, 3'd1, 8, 8'h00, 1'b0);
    env("R9 half boundary above", 1'b0, 1'b1, 15'h4000);
    env("R9 half boundary below", 1'b0, 1'b1, 15'h3FFF);
    frame("R7 write done clears", 1'b0, 3'd0, 0, 8'h00, 1'b1);
    frame("R10 enable with write done", 1'b1, 3'd1, 8, 8'h00, 1'b1);
    env("R6 pin ignored without enable bit", 1'b0, 1'b0, 15'h3FFF);
    frame("R6 status write with pin low", 1'b1, 3'd3, 16, 8'h00, 1'b0);
    frame("R3 enable", 1'b1, 3'd1, 8, 8'h00, 1'b0);
    env("R9 nothing locked", 1'b0, 1'b1, 15'h7FFF);

    wait (sb_q.size() == 0);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule